// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the frame-sync level for a TDM or I2S audio cluster. It counts bit-clock enables taken from one of several source clusters and alternates between a high phase and a low phase. Each phase has its own programmed length, so a frame with an odd number of bit clocks still gets a duty cycle that is as even as possible. A one-cycle frame-start strobe marks the first bit clock of every high phase, and the serializers align their slots to it.

Software sets the block up through a small register port. Four words hold the settings: a control word with the run bit and the source select, the high-phase length, the low-phase length, and a master-clock word with a gate bit and a prescale divider. The registers are written synchronously and read back combinationally. A phase of N bit clocks is programmed as N-1. For a frame of B bit clocks the high length is B/2-1 and the low length is (B+1)/2-1.

Top module: `audio_fsync_gen`

## Requirements
- R1: After reset, `fsync_o` and `frame_start_o` are 0 and all four registers read back as 0.
- R2: Once the run bit (control word bit 0) is set, the first counted bit clock puts `fsync_o` at 1 and pulses `frame_start_o` for exactly one cycle. Every later entry into the high phase pulses the strobe again, and a restart after a disable begins in the high phase.
- R3: With high length H and low length L, `fsync_o` stays high for H+1 counted bit clocks and low for L+1, so a frame lasts H+L+2. Between counted bit clocks the outputs do not change.
- R4: Source select value N+1 (control word bits 7:4) counts only `bclk_en_i[N]`. Enables on all other sources are ignored.
- R5: A source select of 0, or a value above the number of sources, selects no clock. Nothing is counted and `fsync_o` stays low.
- R6: Clearing the run bit drives `fsync_o` low from the second clock edge after the write. While the bit is clear, no strobe is produced, whatever happens on the bit-clock inputs.
- R7: A phase length written while the generator runs is used only when that phase is next loaded, never part-way through a phase. A write that lands on the same clock edge as a reload leaves that reload with the old value.
- R8: While the master-clock gate (master-clock word bit 0) is 0, bit clocks are not counted and `fsync_o` holds its level. Counting resumes where it stopped once the gate is set again.
- R9: The divider field (master-clock word bits 11:8) with value D ≥ 1 counts one bit clock for every D selected enables. A value of 0 behaves as 1.
- R10: Register addresses are 0 = control, 1 = high length, 2 = low length, 3 = master clock. The phase lengths are LEN_W bits wide at bit 0. Bits outside the defined fields are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_en_i | input | NUM_SRC | One bit-clock enable pulse per source cluster |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Combinational register read data |
| fsync_o | output | 1 | Frame-sync level |
| frame_start_o | output | 1 | One-cycle strobe on the first bit clock of each frame |

## Verification
Two functions can fall on the same clock edge: a software write to a phase-length register, and the reload at a phase boundary that reads that register. The bench provokes this by asserting the write strobe and the selected bit-clock enable in the same cycle, exactly when the high phase ends. It then counts the length of the low phase that follows and of the one after it. The old value must govern the first of these low phases and the new value the second. Other directed scenarios interleave disables, gate clears and divider changes with running frames. Each one is judged against a tick-by-tick expected waveform built from the programmed lengths.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_HIGH = 2'd1,
        ADDR_LOW  = 2'd2,
        ADDR_MCLK = 2'd3
    } fsg_addr_e;

    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_SEL_LSB  = 4;
    localparam int unsigned MCLK_GATE_BIT = 0;
    localparam int unsigned MCLK_DIV_LSB  = 8;

endpackage

// File: rtl/fsg_regs.sv
module fsg_regs
    import fsg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned LEN_W  = 10,
    parameter int unsigned DIV_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              run_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [LEN_W-1:0]  high_len_o,
    output logic [LEN_W-1:0]  low_len_o,
    output logic              gate_o,
    output logic [DIV_W-1:0]  div_o
);

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
        logic [LEN_W-1:0] high_len;
        logic [LEN_W-1:0] low_len;
        logic             gate;
        logic [DIV_W-1:0] div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^wr_data_i;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (fsg_addr_e'(wr_addr_i))
                ADDR_CTRL: begin
                    cfg_d.run = wr_data_i[CTRL_RUN_BIT];
                    cfg_d.sel = wr_data_i[CTRL_SEL_LSB +: SEL_W];
                end
                ADDR_HIGH: cfg_d.high_len = wr_data_i[LEN_W-1:0];
                ADDR_LOW:  cfg_d.low_len  = wr_data_i[LEN_W-1:0];
                ADDR_MCLK: begin
                    cfg_d.gate = wr_data_i[MCLK_GATE_BIT];
                    cfg_d.div  = wr_data_i[MCLK_DIV_LSB +: DIV_W];
                end
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data_o = '0;
        case (fsg_addr_e'(rd_addr_i))
            ADDR_CTRL: begin
                rd_data_o[CTRL_RUN_BIT]           = cfg_q.run;
                rd_data_o[CTRL_SEL_LSB +: SEL_W]  = cfg_q.sel;
            end
            ADDR_HIGH: rd_data_o[LEN_W-1:0] = cfg_q.high_len;
            ADDR_LOW:  rd_data_o[LEN_W-1:0] = cfg_q.low_len;
            ADDR_MCLK: begin
                rd_data_o[MCLK_GATE_BIT]          = cfg_q.gate;
                rd_data_o[MCLK_DIV_LSB +: DIV_W]  = cfg_q.div;
            end
            default: rd_data_o = '0;
        endcase
    end

    assign run_o      = cfg_q.run;
    assign sel_o      = cfg_q.sel;
    assign high_len_o = cfg_q.high_len;
    assign low_len_o  = cfg_q.low_len;
    assign gate_o     = cfg_q.gate;
    assign div_o      = cfg_q.div;

    // R10: a control write lands in the run flag on the next edge
    a_r10_run_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == 2'd0) |=> (run_o == $past(wr_data_i[CTRL_RUN_BIT])));

endmodule

// File: rtl/fsg_tick.sv
module fsg_tick #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned DIV_W   = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               run_i,
    input  logic               gate_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [NUM_SRC-1:0] bclk_en_i,
    output logic               tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_t;

    pre_t             st_d, st_q;
    logic [NUM_SRC-1:0] hit;
    logic             raw_en;
    logic [DIV_W-1:0] last_cnt;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = bclk_en_i[g] && (sel_i == SEL_W'(g + 1));
    end

    assign raw_en   = |hit;
    assign last_cnt = (div_i == '0) ? '0 : div_i - DIV_W'(1);

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        if (!run_i || !gate_i) begin
            st_d.pre = '0;
        end else if (raw_en) begin
            if (st_q.pre >= last_cnt) begin
                tick_o   = 1'b1;
                st_d.pre = '0;
            end else begin
                st_d.pre = st_q.pre + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R4: no counted bit clock without an enable on some source
    a_r4_tick_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (bclk_en_i != '0));

endmodule

// File: rtl/fsg_phase.sv
module fsg_phase #(
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [LEN_W-1:0] high_len_i,
    input  logic [LEN_W-1:0] low_len_i,
    output logic             fsync_o,
    output logic             frame_start_o
);

    typedef struct packed {
        logic             active;
        logic             high;
        logic             strobe;
        logic [LEN_W-1:0] cnt;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (!run_i) begin
            st_d = '0;
        end else if (tick_i) begin
            if (!st_q.active) begin
                st_d.active = 1'b1;
                st_d.high   = 1'b1;
                st_d.strobe = 1'b1;
                st_d.cnt    = high_len_i;
            end else if (st_q.cnt == '0) begin
                if (st_q.high) begin
                    st_d.high = 1'b0;
                    st_d.cnt  = low_len_i;
                end else begin
                    st_d.high   = 1'b1;
                    st_d.strobe = 1'b1;
                    st_d.cnt    = high_len_i;
                end
            end else begin
                st_d.cnt = st_q.cnt - LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fsync_o       = st_q.active && st_q.high;
    assign frame_start_o = st_q.strobe;

    // R2: the strobe only marks the high phase
    a_r2_strobe_in_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> fsync_o);

    // R2: the strobe is a single-cycle pulse
    a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> !frame_start_o);

    // R3: the level moves only on a counted bit clock
    a_r3_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> $stable(fsync_o));

    // R6: stopped generator drives low with no strobe
    a_r6_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!fsync_o && !frame_start_o));

endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned LEN_W   = 10,
    parameter int unsigned DIV_W   = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] bclk_en_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [1:0]         rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               fsync_o,
    output logic               frame_start_o
);

    logic             run_w;
    logic [SEL_W-1:0] sel_w;
    logic [LEN_W-1:0] high_len_w;
    logic [LEN_W-1:0] low_len_w;
    logic             gate_w;
    logic [DIV_W-1:0] div_w;
    logic             tick_w;

    fsg_regs #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .LEN_W  (LEN_W),
        .DIV_W  (DIV_W)
    ) i_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .run_o      (run_w),
        .sel_o      (sel_w),
        .high_len_o (high_len_w),
        .low_len_o  (low_len_w),
        .gate_o     (gate_w),
        .div_o      (div_w)
    );

    fsg_tick #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W),
        .DIV_W   (DIV_W)
    ) i_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_w),
        .gate_i    (gate_w),
        .sel_i     (sel_w),
        .div_i     (div_w),
        .bclk_en_i (bclk_en_i),
        .tick_o    (tick_w)
    );

    fsg_phase #(
        .LEN_W (LEN_W)
    ) i_phase (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .run_i         (run_w),
        .tick_i        (tick_w),
        .high_len_i    (high_len_w),
        .low_len_i     (low_len_w),
        .fsync_o       (fsync_o),
        .frame_start_o (frame_start_o)
    );

    // R5: no selected source, no movement of the level
    a_r5_no_source_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && sel_w == '0) |=> $stable(fsync_o));

    // R8: closed master-clock gate freezes the level
    a_r8_gate_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && !gate_w) |=> ($stable(fsync_o) && !frame_start_o));

endmodule

// File: tb/test_audio_fsync_gen.sv
module test_audio_fsync_gen;

    localparam int NUM_SRC = 6;
    localparam int DATA_W  = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_SRC-1:0] bclk_en = '0;
    logic               wr_en = 1'b0;
    logic [1:0]         wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [1:0]         rd_addr = '0;
    logic [DATA_W-1:0]  rd_data;
    logic               fsync;
    logic               fstart;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    audio_fsync_gen i_audio_fsync_gen (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .bclk_en_i     (bclk_en),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .fsync_o       (fsync),
        .frame_start_o (fstart)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic bit_tick(input logic [NUM_SRC-1:0] m, output logic fs, output logic st);
        @(negedge clk);
        bclk_en = m;
        @(negedge clk);
        fs = fsync; st = fstart;
        bclk_en = '0;
    endtask

    // n ticks on source 0; level fs expected throughout, strobe on the first only if first_st
    task automatic run_ticks(input string req, input int n, input int fs_exp, input int first_st);
        logic fs, st;
        for (int k = 0; k < n; k++) begin
            bit_tick(6'b000001, fs, st);
            chk(req, fs, fs_exp);
            chk(req, st, (k == 0) ? first_st : 0);
        end
    endtask

    task automatic setup(input int sel, input int hi, input int lo, input int mclk);
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd3, mclk);
        reg_wr(2'd1, hi);
        reg_wr(2'd2, lo);
        reg_wr(2'd0, (sel << 4) | 1);
    endtask

    task automatic t_reset;
        logic [DATA_W-1:0] d;
        chk("R1 fsync", fsync, 0);
        chk("R1 strobe", fstart, 0);
        for (int a = 0; a < 4; a++) begin
            reg_rd(a[1:0], d);
            chk("R1 reg", d, 0);
        end
    endtask

    task automatic t_regs;
        logic [DATA_W-1:0] d;
        reg_wr(2'd0, 32'hFFFF_FF50);
        reg_rd(2'd0, d); chk("R10 ctrl", d, 32'h50);
        reg_wr(2'd1, 32'hFFFF_F2AB);
        reg_rd(2'd1, d); chk("R10 high", d, 32'h2AB);
        reg_wr(2'd2, 32'h0000_0155);
        reg_rd(2'd2, d); chk("R10 low", d, 32'h155);
        reg_wr(2'd3, 32'hFFFF_FFFF);
        reg_rd(2'd3, d); chk("R10 mclk", d, 32'hF01);
        reg_wr(2'd0, 32'h0);
    endtask

    task automatic t_frame(input int hi, input int lo);
        int b;
        logic fs, st;
        b = hi + lo + 2;
        setup(1, hi, lo, 32'h101);
        for (int k = 0; k < 2 * b + 1; k++) begin
            bit_tick(6'b000001, fs, st);
            chk("R3 level", fs, ((k % b) < hi + 1) ? 1 : 0);
            chk("R2 strobe", st, ((k % b) == 0) ? 1 : 0);
        end
    endtask

    task automatic t_wrong_src;
        logic fs, st;
        setup(3, 1, 1, 32'h101);
        bit_tick(6'b111011, fs, st);
        chk("R4 other sources", fs, 0);
        chk("R4 other sources strobe", st, 0);
        bit_tick(6'b000100, fs, st);
        chk("R4 own source", fs, 1);
        chk("R4 own source strobe", st, 1);
    endtask

    task automatic t_no_source;
        logic fs, st;
        setup(0, 1, 1, 32'h101);
        for (int k = 0; k < 3; k++) begin
            bit_tick('1, fs, st);
            chk("R5 select zero", fs, 0);
            chk("R5 select zero strobe", st, 0);
        end
        setup(7, 1, 1, 32'h101);
        bit_tick('1, fs, st);
        chk("R5 select out of range", fs, 0);
        chk("R5 select out of range strobe", st, 0);
    endtask

    task automatic t_disable;
        setup(1, 3, 4, 32'h101);
        run_ticks("R2 enter", 1, 1, 1);
        run_ticks("R3 high", 1, 1, 0);
        reg_wr(2'd0, 32'h10);
        @(negedge clk);
        chk("R6 low after clear", fsync, 0);
        run_ticks("R6 stopped", 4, 0, 0);
        reg_wr(2'd0, 32'h11);
        run_ticks("R2 restart high", 1, 1, 1);
    endtask

    task automatic t_live_update;
        setup(1, 3, 4, 32'h101);
        run_ticks("R7 start", 1, 1, 1);
        run_ticks("R7 start", 1, 1, 0);
        reg_wr(2'd1, 32'd1);
        run_ticks("R7 high unchanged", 2, 1, 0);
        run_ticks("R7 low", 5, 0, 0);
        run_ticks("R7 new high", 2, 1, 1);
        run_ticks("R7 low", 1, 0, 0);
        reg_wr(2'd2, 32'd0);
        run_ticks("R7 low unchanged", 4, 0, 0);
        run_ticks("R7 high", 2, 1, 1);
        run_ticks("R7 new low", 1, 0, 0);
        run_ticks("R7 high again", 1, 1, 1);
    endtask

    task automatic t_same_edge;
        setup(1, 0, 2, 32'h101);
        run_ticks("R7 edge start", 1, 1, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd0; bclk_en = 6'b000001;
        @(negedge clk);
        wr_en = 1'b0; bclk_en = '0;
        chk("R7 same edge to low", fsync, 0);
        run_ticks("R7 same edge old low", 2, 0, 0);
        run_ticks("R7 same edge high", 1, 1, 1);
        run_ticks("R7 same edge new low", 1, 0, 0);
        run_ticks("R7 same edge next frame", 1, 1, 1);
    endtask

    task automatic t_gate;
        setup(1, 3, 4, 32'h101);
        run_ticks("R8 run", 1, 1, 1);
        run_ticks("R8 run", 1, 1, 0);
        reg_wr(2'd3, 32'h100);
        run_ticks("R8 frozen", 6, 1, 0);
        reg_wr(2'd3, 32'h101);
        run_ticks("R8 resume high", 2, 1, 0);
        run_ticks("R8 resume low", 5, 0, 0);
        run_ticks("R8 next frame", 1, 1, 1);
    endtask

    task automatic t_div;
        setup(1, 3, 4, 32'h301);
        run_ticks("R9 divide three", 2, 0, 0);
        run_ticks("R9 third enable", 1, 1, 1);
        run_ticks("R9 divide three", 3, 1, 0);
        setup(1, 0, 0, 32'h001);
        run_ticks("R9 divide zero", 1, 1, 1);
        run_ticks("R9 divide zero", 1, 0, 0);
        run_ticks("R9 divide zero", 1, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_frame(3, 4);
        t_frame(0, 0);
        t_frame(7, 7);
        t_wrong_src();
        t_no_source();
        t_disable();
        t_live_update();
        t_same_edge();
        t_gate();
        t_div();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule